// File: doc/BRIEF.md
# Two-Stage Separable Switch Allocator

This block performs switch allocation for a virtual-channel network-on-chip router with `NPORT` input ports and `NPORT` output ports. Each input port holds `NVC` virtual channels, split evenly into `NVNET` virtual networks. Every cycle, each virtual channel reports four things: whether it has a flit waiting for allocation, its output port, whether it already owns an output VC (and which one), and whether the waiting flit ends its packet. The router also supplies two masks for every output port: which output VCs are free, and which output VCs have at least one downstream credit.

Allocation is separable and input-first. In the first stage, every input port picks one eligible VC with its own round-robin pointer. In the second stage, every output port picks one of the inputs that selected it, again with its own round-robin pointer. A winning head flit that owns no output VC gets the lowest-numbered free output VC of its own virtual network at the chosen port. Grants, the assigned output VC, the credit-return flag and the crossbar selects are registered, so they appear one cycle after the request. Pending requests are not stored: each cycle is allocated from that cycle's inputs alone.

There is no state machine. The only state is two banks of round-robin pointers and the output registers.

Top module: `swa_top`

## Requirements
- R1: While reset is active and in the first cycle after it, every output is zero, and both pointer banks start at index 0.
- R2: A ready VC that owns output VC `o` at port `p` is eligible only if `ovc_credit[p*NVC+o]` is 1. A ready VC with no output VC is eligible only if at least one bit of `ovc_free` is set among port `p`'s VCs of its own virtual network (network = VC index / (NVC/NVNET)). A VC that is not ready or not eligible never wins.
- R3: Each input picks the first eligible VC, scanning upward from its pointer with wrap. The pointer then becomes the winner index plus one, wrapping to 0 at `NVC`. If the input has no eligible VC, the pointer keeps its value.
- R4: Each output grants the first input that selected it, scanning upward from its pointer with wrap. The pointer then becomes the granted input plus one, wrapping to 0 at `NPORT`. If no input selected the output, the pointer keeps its value.
- R5: An input that wins the first stage but loses the second gets no grant, and its first-stage pointer has still advanced past the VC it picked.
- R6: A granted VC that already owns an output VC reports that VC, with `gnt_alloc` at 0. A granted VC that owns none reports the lowest-indexed free output VC of its virtual network at its port, with `gnt_alloc` at 1.
- R7: `crd_free[i]` is 1 exactly when input `i` is granted and its granted flit ends its packet. `gnt_valid[i]` itself is the credit return for the granted VC.
- R8: `xbar_valid[o]` is 1 exactly when some input was granted output `o`, and `xbar_sel[o]` is then that input's index.
- R9: All results appear on the clock edge after the inputs are sampled. A request that loses is not remembered: if no VC is ready, no grant follows.
- R10: Per cycle, at most one grant goes to each input and at most one to each output. Fields of an input that is not granted read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_ready | input | NPORT*NVC | VC has a flit waiting for allocation (input i, VC v at bit i*NVC+v) |
| vc_port | input | NPORT*NVC*PW | Output port wanted by each VC |
| vc_has_ovc | input | NPORT*NVC | VC already owns an output VC |
| vc_ovc | input | NPORT*NVC*VW | Output VC owned, when vc_has_ovc is 1 |
| vc_tail | input | NPORT*NVC | Waiting flit is the last of its packet |
| ovc_free | input | NPORT*NVC | Output VC free (port p, VC o at bit p*NVC+o) |
| ovc_credit | input | NPORT*NVC | Output VC has at least one credit |
| gnt_valid | output | NPORT | Input granted; also the credit return |
| gnt_vc | output | NPORT*VW | Granted input VC |
| gnt_port | output | NPORT*PW | Output port of the grant |
| gnt_ovc | output | NPORT*VW | Output VC that tags the flit |
| gnt_alloc | output | NPORT | Output VC newly assigned this grant |
| crd_free | output | NPORT | Credit return also frees the input VC |
| xbar_valid | output | NPORT | Crossbar output in use |
| xbar_sel | output | NPORT*PW | Input driving each crossbar output |

## Verification
The bench builds the block with three ports, four VCs and two virtual networks. With three ports, the output pointer wraps at a count that is not a power of two, and a two-bit index can hold the unused value 3. With two VCs per network, both the credit check and the lowest-free-VC choice have a real alternative. Directed patterns make several inputs contend for one port, which makes second-stage losses and the pointer advance they leave behind visible. Long runs of biased random traffic are then compared against a behavioural model on every cycle.

// File: rtl/swa_pkg.sv
package swa_pkg;

    // Round-robin successor of idx in a ring of n entries.
    function automatic int wrap_next(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/swa_rr_pick.sv
module swa_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        int c;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            c = int'(ptr) + k;
            if (c >= N) c = c - N;
            if (!found && req[c]) begin
                found = 1'b1;
                idx   = IW'(c);
            end
        end
    end

endmodule

// File: rtl/swa_in_stage.sv
module swa_in_stage #(
    parameter int NPORT = 4,
    parameter int NVC   = 4,
    parameter int NVNET = 2,
    parameter int PW    = 2,
    parameter int VW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NVC-1:0]        vc_ready,
    input  logic [NVC*PW-1:0]     vc_port,
    input  logic [NVC-1:0]        vc_has_ovc,
    input  logic [NVC*VW-1:0]     vc_ovc,
    input  logic [NVC-1:0]        vc_tail,
    input  logic [NPORT*NVC-1:0]  ovc_free,
    input  logic [NPORT*NVC-1:0]  ovc_credit,
    output logic                  req_valid,
    output logic [PW-1:0]         req_port,
    output logic [VW-1:0]         req_vc,
    output logic [VW-1:0]         req_ovc,
    output logic                  req_alloc,
    output logic                  req_tail
);
    import swa_pkg::*;

    localparam int VPN = NVC / NVNET;

    logic [NVC-1:0] elig;
    logic [VW-1:0]  ptr_q;
    logic           pick_found;
    logic [VW-1:0]  pick_idx;

    // Eligibility: credit on owned output VC, or a free VC in the network.
    always_comb begin
        int p;
        int o;
        int vn;
        logic any_free;
        for (int v = 0; v < NVC; v++) begin
            p  = int'(vc_port[v*PW +: PW]);
            o  = int'(vc_ovc[v*VW +: VW]);
            vn = v / VPN;
            any_free = 1'b0;
            elig[v]  = 1'b0;
            if (p < NPORT) begin
                for (int j = 0; j < VPN; j++)
                    any_free = any_free | ovc_free[p*NVC + vn*VPN + j];
                if (vc_has_ovc[v])
                    elig[v] = vc_ready[v] & ovc_credit[p*NVC + o];
                else
                    elig[v] = vc_ready[v] & any_free;
            end
        end
    end

    swa_rr_pick #(.N(NVC), .IW(VW)) u_pick (
        .req   (elig),
        .ptr   (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (pick_found)
            ptr_q <= VW'(wrap_next(int'(pick_idx), NVC));
    end

    // Winner fields and output-VC choice for a head flit.
    always_comb begin
        int w;
        int p;
        int vn;
        logic [VW-1:0] low_free;
        w  = int'(pick_idx);
        p  = int'(vc_port[w*PW +: PW]);
        vn = w / VPN;
        low_free = '0;
        if (p < NPORT) begin
            for (int j = VPN - 1; j >= 0; j--)
                if (ovc_free[p*NVC + vn*VPN + j])
                    low_free = VW'(vn*VPN + j);
        end
        req_valid = pick_found;
        req_vc    = pick_idx;
        req_port  = vc_port[w*PW +: PW];
        req_tail  = vc_tail[w];
        req_alloc = ~vc_has_ovc[w];
        req_ovc   = vc_has_ovc[w] ? vc_ovc[w*VW +: VW] : low_free;
    end

endmodule

// File: rtl/swa_out_stage.sv
module swa_out_stage #(
    parameter int NPORT = 4,
    parameter int PW    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPORT-1:0]          req_valid,
    input  logic [NPORT-1:0][PW-1:0]  req_port,
    output logic [NPORT-1:0]          out_found,
    output logic [NPORT-1:0][PW-1:0]  out_sel
);
    import swa_pkg::*;

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        logic [NPORT-1:0] want;
        logic [PW-1:0]    ptr_q;

        always_comb begin
            for (int i = 0; i < NPORT; i++)
                want[i] = req_valid[i] && (int'(req_port[i]) == go);
        end

        swa_rr_pick #(.N(NPORT), .IW(PW)) u_pick (
            .req   (want),
            .ptr   (ptr_q),
            .found (out_found[go]),
            .idx   (out_sel[go])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (out_found[go])
                ptr_q <= PW'(wrap_next(int'(out_sel[go]), NPORT));
        end
    end

endmodule

// File: rtl/swa_top.sv
module swa_top #(
    parameter int NPORT = 4,
    parameter int NVC   = 4,
    parameter int NVNET = 2,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT*NVC-1:0]     vc_ready,
    input  logic [NPORT*NVC*PW-1:0]  vc_port,
    input  logic [NPORT*NVC-1:0]     vc_has_ovc,
    input  logic [NPORT*NVC*VW-1:0]  vc_ovc,
    input  logic [NPORT*NVC-1:0]     vc_tail,
    input  logic [NPORT*NVC-1:0]     ovc_free,
    input  logic [NPORT*NVC-1:0]     ovc_credit,
    output logic [NPORT-1:0]         gnt_valid,
    output logic [NPORT*VW-1:0]      gnt_vc,
    output logic [NPORT*PW-1:0]      gnt_port,
    output logic [NPORT*VW-1:0]      gnt_ovc,
    output logic [NPORT-1:0]         gnt_alloc,
    output logic [NPORT-1:0]         crd_free,
    output logic [NPORT-1:0]         xbar_valid,
    output logic [NPORT*PW-1:0]      xbar_sel
);

    logic [NPORT-1:0]          req_valid;
    logic [NPORT-1:0][PW-1:0]  req_port;
    logic [NPORT-1:0][VW-1:0]  req_vc;
    logic [NPORT-1:0][VW-1:0]  req_ovc;
    logic [NPORT-1:0]          req_alloc;
    logic [NPORT-1:0]          req_tail;
    logic [NPORT-1:0]          out_found;
    logic [NPORT-1:0][PW-1:0]  out_sel;
    logic [NPORT-1:0]          in_gnt;

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        swa_in_stage #(
            .NPORT (NPORT), .NVC (NVC), .NVNET (NVNET), .PW (PW), .VW (VW)
        ) u_in (
            .clk        (clk),
            .rst_n      (rst_n),
            .vc_ready   (vc_ready[gi*NVC +: NVC]),
            .vc_port    (vc_port[gi*NVC*PW +: NVC*PW]),
            .vc_has_ovc (vc_has_ovc[gi*NVC +: NVC]),
            .vc_ovc     (vc_ovc[gi*NVC*VW +: NVC*VW]),
            .vc_tail    (vc_tail[gi*NVC +: NVC]),
            .ovc_free   (ovc_free),
            .ovc_credit (ovc_credit),
            .req_valid  (req_valid[gi]),
            .req_port   (req_port[gi]),
            .req_vc     (req_vc[gi]),
            .req_ovc    (req_ovc[gi]),
            .req_alloc  (req_alloc[gi]),
            .req_tail   (req_tail[gi])
        );
    end

    swa_out_stage #(.NPORT (NPORT), .PW (PW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_port  (req_port),
        .out_found (out_found),
        .out_sel   (out_sel)
    );

    // Fold per-output winners back onto the inputs.
    always_comb begin
        in_gnt = '0;
        for (int o = 0; o < NPORT; o++)
            if (out_found[o])
                in_gnt[out_sel[o]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid  <= '0;
            gnt_vc     <= '0;
            gnt_port   <= '0;
            gnt_ovc    <= '0;
            gnt_alloc  <= '0;
            crd_free   <= '0;
            xbar_valid <= '0;
            xbar_sel   <= '0;
        end else begin
            for (int i = 0; i < NPORT; i++) begin
                gnt_valid[i]         <= in_gnt[i];
                gnt_vc[i*VW +: VW]   <= in_gnt[i] ? req_vc[i]   : '0;
                gnt_port[i*PW +: PW] <= in_gnt[i] ? req_port[i] : '0;
                gnt_ovc[i*VW +: VW]  <= in_gnt[i] ? req_ovc[i]  : '0;
                gnt_alloc[i]         <= in_gnt[i] & req_alloc[i];
                crd_free[i]          <= in_gnt[i] & req_tail[i];
            end
            for (int o = 0; o < NPORT; o++) begin
                xbar_valid[o]        <= out_found[o];
                xbar_sel[o*PW +: PW] <= out_found[o] ? out_sel[o] : '0;
            end
        end
    end

endmodule

// File: rtl/swa_top_chk.sv
module swa_top_chk #(
    parameter int NPORT = 4,
    parameter int NVC   = 4,
    parameter int NVNET = 2,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW   = (NVC > 1) ? $clog2(NVC) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORT*NVC-1:0]     vc_ready,
    input logic [NPORT*NVC-1:0]     vc_has_ovc,
    input logic [NPORT*NVC-1:0]     vc_tail,
    input logic [NPORT*NVC-1:0]     ovc_free,
    input logic [NPORT-1:0]         gnt_valid,
    input logic [NPORT*VW-1:0]      gnt_vc,
    input logic [NPORT*PW-1:0]      gnt_port,
    input logic [NPORT*VW-1:0]      gnt_ovc,
    input logic [NPORT-1:0]         gnt_alloc,
    input logic [NPORT-1:0]         crd_free,
    input logic [NPORT-1:0]         xbar_valid,
    input logic [NPORT*PW-1:0]      xbar_sel
);
    localparam int VPN = NVC / NVNET;

    logic                 armed;
    logic [NPORT*NVC-1:0] p_ready;
    logic [NPORT*NVC-1:0] p_has;
    logic [NPORT*NVC-1:0] p_tail;
    logic [NPORT*NVC-1:0] p_free;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            p_ready <= '0;
            p_has   <= '0;
            p_tail  <= '0;
            p_free  <= '0;
        end else begin
            armed   <= 1'b1;
            p_ready <= vc_ready;
            p_has   <= vc_has_ovc;
            p_tail  <= vc_tail;
            p_free  <= ovc_free;
        end
    end

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_chk
        // R8
        xbar_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[gi] |-> (xbar_valid[gnt_port[gi*PW +: PW]] &&
                (int'(xbar_sel[int'(gnt_port[gi*PW +: PW])*PW +: PW]) == gi)));

        // R10
        xbar_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xbar_valid[gi] |-> (gnt_valid[xbar_sel[gi*PW +: PW]] &&
                (int'(gnt_port[int'(xbar_sel[gi*PW +: PW])*PW +: PW]) == gi)));

        // R9
        grant_was_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && gnt_valid[gi]) |-> p_ready[gi*NVC + int'(gnt_vc[gi*VW +: VW])]);

        // R7
        free_on_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && crd_free[gi]) |->
                (gnt_valid[gi] && p_tail[gi*NVC + int'(gnt_vc[gi*VW +: VW])]));

        // R6
        alloc_was_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && gnt_alloc[gi]) |->
                (p_free[int'(gnt_port[gi*PW +: PW])*NVC + int'(gnt_ovc[gi*VW +: VW])] &&
                 !p_has[gi*NVC + int'(gnt_vc[gi*VW +: VW])]));

        // R6
        same_vnet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[gi] |->
                ((int'(gnt_ovc[gi*VW +: VW]) / VPN) == (int'(gnt_vc[gi*VW +: VW]) / VPN)));
    end

endmodule

bind swa_top swa_top_chk #(.NPORT(NPORT), .NVC(NVC), .NVNET(NVNET)) u_swa_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vc_ready   (vc_ready),
    .vc_has_ovc (vc_has_ovc),
    .vc_tail    (vc_tail),
    .ovc_free   (ovc_free),
    .gnt_valid  (gnt_valid),
    .gnt_vc     (gnt_vc),
    .gnt_port   (gnt_port),
    .gnt_ovc    (gnt_ovc),
    .gnt_alloc  (gnt_alloc),
    .crd_free   (crd_free),
    .xbar_valid (xbar_valid),
    .xbar_sel   (xbar_sel)
);

// File: tb/test_swa_top.sv
module test_swa_top;
    localparam int P   = 3;
    localparam int V   = 4;
    localparam int NV  = 2;
    localparam int VPN = V / NV;
    localparam int PW  = 2;
    localparam int VW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [P*V-1:0]    vc_ready = '0;
    logic [P*V*PW-1:0] vc_port = '0;
    logic [P*V-1:0]    vc_has_ovc = '0;
    logic [P*V*VW-1:0] vc_ovc = '0;
    logic [P*V-1:0]    vc_tail = '0;
    logic [P*V-1:0]    ovc_free = '0;
    logic [P*V-1:0]    ovc_credit = '0;
    logic [P-1:0]      gnt_valid, gnt_alloc, crd_free, xbar_valid;
    logic [P*VW-1:0]   gnt_vc, gnt_ovc;
    logic [P*PW-1:0]   gnt_port, xbar_sel;

    swa_top #(.NPORT(P), .NVC(V), .NVNET(NV)) i_swa_top (
        .clk(clk), .rst_n(rst_n), .vc_ready(vc_ready), .vc_port(vc_port),
        .vc_has_ovc(vc_has_ovc), .vc_ovc(vc_ovc), .vc_tail(vc_tail),
        .ovc_free(ovc_free), .ovc_credit(ovc_credit), .gnt_valid(gnt_valid),
        .gnt_vc(gnt_vc), .gnt_port(gnt_port), .gnt_ovc(gnt_ovc),
        .gnt_alloc(gnt_alloc), .crd_free(crd_free), .xbar_valid(xbar_valid),
        .xbar_sel(xbar_sel)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    int iptr[P];
    int optr[P];
    int e_gv[P], e_vc[P], e_port[P], e_ovc[P], e_alloc[P], e_crd[P];
    int e_xv[P], e_xs[P];

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic set_vc(int i, int v, bit rdy, int port, bit has, int ovc, bit tail);
        vc_ready[i*V+v]         = rdy;
        vc_port[(i*V+v)*PW +: PW] = PW'(port);
        vc_has_ovc[i*V+v]       = has;
        vc_ovc[(i*V+v)*VW +: VW]  = VW'(ovc);
        vc_tail[i*V+v]          = tail;
    endtask

    // Expected results of the cycle whose inputs are now applied.
    task automatic model();
        int win[P];
        int wovc[P];
        int walloc[P];
        for (int i = 0; i < P; i++) begin
            win[i] = -1; wovc[i] = 0; walloc[i] = 0;
            for (int k = 0; k < V; k++) begin
                int v, p, vn, o;
                bit ok;
                v  = (iptr[i] + k) % V;
                p  = int'(vc_port[(i*V+v)*PW +: PW]);
                o  = int'(vc_ovc[(i*V+v)*VW +: VW]);
                vn = v / VPN;
                ok = 0;
                if (vc_ready[i*V+v]) begin
                    if (vc_has_ovc[i*V+v]) ok = ovc_credit[p*V+o];
                    else for (int j = 0; j < VPN; j++) if (ovc_free[p*V+vn*VPN+j]) ok = 1;
                end
                if (ok) begin
                    win[i] = v;
                    iptr[i] = (v + 1) % V;
                    if (vc_has_ovc[i*V+v]) wovc[i] = o;
                    else begin
                        walloc[i] = 1;
                        for (int j = VPN - 1; j >= 0; j--)
                            if (ovc_free[p*V+vn*VPN+j]) wovc[i] = vn*VPN + j;
                    end
                    break;
                end
            end
        end
        for (int i = 0; i < P; i++) begin
            e_gv[i] = 0; e_vc[i] = 0; e_port[i] = 0; e_ovc[i] = 0;
            e_alloc[i] = 0; e_crd[i] = 0; e_xv[i] = 0; e_xs[i] = 0;
        end
        for (int o = 0; o < P; o++) begin
            for (int k = 0; k < P; k++) begin
                int i;
                i = (optr[o] + k) % P;
                if (win[i] >= 0 && int'(vc_port[(i*V+win[i])*PW +: PW]) == o) begin
                    e_xv[o] = 1; e_xs[o] = i;
                    e_gv[i] = 1; e_vc[i] = win[i]; e_port[i] = o;
                    e_ovc[i] = wovc[i]; e_alloc[i] = walloc[i];
                    e_crd[i] = vc_tail[i*V+win[i]];
                    optr[o] = (i + 1) % P;
                    break;
                end
            end
        end
    endtask

    task automatic compare(string tag);
        for (int i = 0; i < P; i++) begin
            check({"R4/R10 grant ", tag}, "gnt_valid", int'(gnt_valid[i]), e_gv[i]);
            check({"R3 vc ", tag}, "gnt_vc", int'(gnt_vc[i*VW +: VW]), e_vc[i]);
            check({"R4 port ", tag}, "gnt_port", int'(gnt_port[i*PW +: PW]), e_port[i]);
            check({"R6 ovc ", tag}, "gnt_ovc", int'(gnt_ovc[i*VW +: VW]), e_ovc[i]);
            check({"R6 alloc ", tag}, "gnt_alloc", int'(gnt_alloc[i]), e_alloc[i]);
            check({"R7 credit ", tag}, "crd_free", int'(crd_free[i]), e_crd[i]);
            check({"R8 xbar ", tag}, "xbar_valid", int'(xbar_valid[i]), e_xv[i]);
            check({"R8 xbar ", tag}, "xbar_sel", int'(xbar_sel[i*PW +: PW]), e_xs[i]);
        end
    endtask

    // Inputs are applied at a falling edge; results read at the next one.
    task automatic step(string tag);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_inputs();
        vc_ready = '0; vc_port = '0; vc_has_ovc = '0; vc_ovc = '0;
        vc_tail = '0; ovc_free = '0; ovc_credit = '0;
    endtask

    task automatic random_inputs(int busy);
        for (int i = 0; i < P; i++)
            for (int v = 0; v < V; v++)
                set_vc(i, v, ($urandom % 100) < busy, $urandom % P, $urandom % 2,
                       (v / VPN) * VPN + ($urandom % VPN), $urandom % 2);
        for (int b = 0; b < P*V; b++) begin
            ovc_free[b]   = ($urandom % 3) == 0;
            ovc_credit[b] = ($urandom % 4) != 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < P; i++) begin iptr[i] = 0; optr[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: outputs held at zero under reset
        check("R1", "gnt_valid", int'(gnt_valid), 0);
        check("R1", "xbar_valid", int'(xbar_valid), 0);
        check("R1", "crd_free", int'(crd_free), 0);
        rst_n = 1'b1;
        step("R1 idle after reset");

        // R2: owned output VC without credit blocks, credit unblocks
        set_vc(0, 1, 1, 2, 1, 0, 0);
        ovc_credit = '0; ovc_free = '1;
        step("R2 no credit");
        ovc_credit[2*V+0] = 1'b1;
        step("R2 credit present");
        // R2: head flit blocked when only the other network has free VCs
        clear_inputs();
        set_vc(1, 3, 1, 0, 0, 0, 1);
        ovc_free[0*V+0] = 1'b1;
        step("R2 no free in own network");
        ovc_free[0*V+3] = 1'b1;
        ovc_free[0*V+2] = 1'b1;
        step("R2 lowest free in network");

        // R5: all inputs contend for port 1; losers still advance
        clear_inputs();
        ovc_free = '1; ovc_credit = '1;
        for (int i = 0; i < P; i++)
            for (int v = 0; v < V; v++)
                set_vc(i, v, 1, 1, 1, v, v == 3);
        for (int n = 0; n < 8; n++) step("R5 contention");

        // R9: nothing ready, no grant follows
        vc_ready = '0;
        step("R9 idle");
        step("R9 idle");

        // R3 R4 R10: random traffic at several loads
        for (int n = 0; n < 3000; n++) begin
            random_inputs(n < 1000 ? 30 : (n < 2000 ? 70 : 100));
            step("random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule